// File: doc/BRIEF.md
# Fixed-Priority Burst DMA Channel Scheduler

This block decides which of several DMA channels the single shared transfer engine serves. Each channel presents an enable flag (the channel has a command loaded), a device request line (its peripheral FIFO wants service) and a programmed burst length. A channel may compete only while both its flag and its request are high. The winner, chosen by fixed priority with the lowest index first, keeps the engine for a whole burst. The scheduler counts the engine's beats against that channel's length and releases the engine only at the end of the burst or when the engine reports that the channel's command has finished.

At every release the scheduler re-arbitrates on the same clock edge, so bursts run back to back without a dead cycle. An enabled channel whose device has stopped requesting, for example a transmitter whose FIFO is full, is passed over. Such a channel can drop out and come back many times during one transfer. When no channel is eligible, the grant is all zeros and the engine idles until a request appears.

Top module: `dma_burst_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `grant` is all zeros, `busy` is 0 and `cur_ch` is 0.
- R2: A channel is eligible only when both its `ch_active` bit and its `ch_req` bit are 1. A channel that is not eligible is never newly granted, whatever its other input says.
- R3: When arbitration takes place, the eligible channel with the lowest index wins. Channel 0 has the highest priority.
- R4: The burst-length field of channel i is `ch_len[i*LEN_W +: LEN_W]`, and a value L means a burst of L+1 beats. The grant holds through L beats and is released on the edge at which the (L+1)-th `beat` is sampled.
- R5: During a burst the grant and `cur_ch` stay unchanged whatever happens to any channel's `ch_active` or `ch_req`, until the burst ends.
- R6: `cmd_end` high while a channel is granted ends that channel's burst at the next edge, however many beats remain.
- R7: On the edge that ends a burst, a new grant goes to the highest-priority channel that is eligible in that cycle, with no idle cycle between. The channel just released competes like any other.
- R8: With no channel granted and none eligible, `grant` stays all zeros. A grant appears on the first edge at which any channel is eligible.
- R9: `grant` is one-hot while `busy` is 1 and zero otherwise. `cur_ch` is the index of the set grant bit, or 0 when idle.
- R10: Only cycles with `beat` high count toward the burst. With `beat` low the grant holds indefinitely. The counter reloads from the new channel's length at every grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_active | input | NUM_CH | Per-channel enable: the channel has a command loaded |
| ch_req | input | NUM_CH | Per-channel device request (the FIFO wants service) |
| ch_len | input | NUM_CH*LEN_W | Packed burst lengths; field i holds beats-minus-one for channel i |
| beat | input | 1 | Engine moved one data unit for the granted channel this cycle |
| cmd_end | input | 1 | Engine reports that the granted channel's command has completed |
| grant | output | NUM_CH | One-hot grant to the channel owning the engine |
| cur_ch | output | IDX_W | Index of the granted channel, 0 when idle |
| busy | output | 1 | A channel currently owns the engine |

## Verification
A stale or wrong owner register shows up at once as a `grant`/`cur_ch` pair that disagrees with the request pattern of the previous edge. A corrupted beat counter shows within one burst length, as a release that comes one or more `beat` edges early or late. A fault in the priority picker shows on the first arbitration with two or more eligible channels, and a fault in the release path shows on the very next grant as either a dead cycle or a held grant. The bench therefore samples the grant on every edge around a burst boundary, not only at its end.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

   localparam int unsigned MAX_CHANNELS = 32;

   // width of an index able to address n items (at least one bit)
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int unsigned N  = 6,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]  cand,
   output logic [N-1:0]  win_oh,
   output logic [IW-1:0] win_idx,
   output logic          win_any
);

   if (IW < dma_sched_pkg::idx_bits(N)) begin : g_bad_iw
      $error("dma_prio_pick: IW too narrow for N");
   end

   logic [N:0] taken;   // taken[i]: some lower index is a candidate
   assign taken[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign win_oh[i]    = cand[i] & ~taken[i];
      assign taken[i + 1] = taken[i] | cand[i];
   end

   assign win_any = taken[N];

   always_comb begin
      win_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand[i]) win_idx = IW'(i);
      end
   end

   // R3: the winner is a candidate and no lower-index candidate exists
   always_comb begin
      if (win_any) begin
         assert_pick_lowest_R3: assert (((win_oh & cand) != '0) &&
                                        (((win_oh - 1'b1) & cand) == '0) &&
                                        $onehot(win_oh));
      end
   end

endmodule

// File: rtl/dma_beat_ctr.sv
module dma_beat_ctr #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);

   if (W < 1) begin : g_bad_w
      $error("dma_beat_ctr: W must be at least 1");
   end

   logic [W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              left_q <= '0;
      else if (load)           left_q <= load_val;
      else if (dec && !last)   left_q <= left_q - W'(1);
   end

   assign last = (left_q == '0);

   // R10: each counted beat takes exactly one off the remaining count
   assert_beat_decrement_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && !last) |=> (left_q == $past(left_q) - W'(1)));

   // R4: a load always takes the new channel's length
   assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (left_q == $past(load_val)));

endmodule

// File: rtl/dma_burst_sched.sv
module dma_burst_sched #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned LEN_W  = 4,
   parameter int unsigned IDX_W  = dma_sched_pkg::idx_bits(NUM_CH)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         ch_active,
   input  logic [NUM_CH-1:0]         ch_req,
   input  logic [NUM_CH*LEN_W-1:0]   ch_len,
   input  logic                      beat,
   input  logic                      cmd_end,
   output logic [NUM_CH-1:0]         grant,
   output logic [IDX_W-1:0]          cur_ch,
   output logic                      busy
);

   if (NUM_CH < 2 || NUM_CH > dma_sched_pkg::MAX_CHANNELS) begin : g_bad_n
      $error("dma_burst_sched: NUM_CH out of range");
   end
   if (IDX_W < dma_sched_pkg::idx_bits(NUM_CH)) begin : g_bad_idx
      $error("dma_burst_sched: IDX_W too narrow");
   end

   logic [NUM_CH-1:0] elig;
   logic [NUM_CH-1:0] pick_oh;
   logic [IDX_W-1:0]  pick_idx;
   logic              pick_any;
   logic [LEN_W-1:0]  len_arr [NUM_CH];
   logic              busy_q;
   logic [IDX_W-1:0]  own_q;
   logic              cnt_last;
   logic              release_now;
   logic              take_new;
   logic              count_beat;

   assign elig = ch_active & ch_req;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_len
      assign len_arr[i] = ch_len[i*LEN_W +: LEN_W];
   end

   dma_prio_pick #(.N(NUM_CH), .IW(IDX_W)) i_pick (
      .cand    (elig),
      .win_oh  (pick_oh),
      .win_idx (pick_idx),
      .win_any (pick_any)
   );

   assign release_now = busy_q && (cmd_end || (beat && cnt_last));
   assign take_new    = (!busy_q || release_now) && pick_any;
   assign count_beat  = busy_q && beat && !release_now;

   dma_beat_ctr #(.W(LEN_W)) i_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (take_new),
      .load_val (len_arr[pick_idx]),
      .dec      (count_beat),
      .last     (cnt_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         own_q  <= '0;
      end else if (take_new) begin
         busy_q <= 1'b1;
         own_q  <= pick_idx;
      end else if (release_now) begin
         busy_q <= 1'b0;
         own_q  <= '0;
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_grant
      assign grant[i] = busy_q && (own_q == IDX_W'(i));
   end

   assign cur_ch = own_q;
   assign busy   = busy_q;

   // R9: grant agrees with busy and is one-hot
   assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (busy == (grant != '0)));

   // R5: mid-burst the owner cannot change
   assert_hold_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !cmd_end && !(beat && cnt_last)) |=> (busy_q && $stable(own_q)));

   // R8: nothing eligible while idle keeps the engine idle
   assert_stay_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && (elig == '0)) |=> !busy_q);

   // R2: a fresh grant goes to a channel that was eligible
   assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && (!$past(busy_q) || $past(release_now))) |-> ((grant & $past(elig)) != '0));

   // R7: a release with an eligible channel grants without a gap
   assert_back_to_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (release_now && (elig != '0)) |=> busy_q);

endmodule

// File: tb/test_dma_burst_sched.sv
module test_dma_burst_sched;

   localparam int unsigned NUM_CH = 6;
   localparam int unsigned LEN_W  = 4;
   localparam int unsigned IDX_W  = 3;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic [NUM_CH-1:0]       ch_active = '0;
   logic [NUM_CH-1:0]       ch_req = '0;
   logic [NUM_CH*LEN_W-1:0] ch_len = '0;
   logic                    beat = 1'b0;
   logic                    cmd_end = 1'b0;
   logic [NUM_CH-1:0]       grant;
   logic [IDX_W-1:0]        cur_ch;
   logic                    busy;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dma_burst_sched #(.NUM_CH(NUM_CH), .LEN_W(LEN_W), .IDX_W(IDX_W)) i_dma_burst_sched (
      .clk(clk), .rst_n(rst_n), .ch_active(ch_active), .ch_req(ch_req),
      .ch_len(ch_len), .beat(beat), .cmd_end(cmd_end),
      .grant(grant), .cur_ch(cur_ch), .busy(busy)
   );

   // {active, request, expected grant}
   localparam logic [17:0] VEC [8] = '{
      {6'h3F, 6'h3F, 6'h01},
      {6'h3E, 6'h3F, 6'h02},
      {6'h3F, 6'h30, 6'h10},
      {6'h0F, 6'h30, 6'h00},
      {6'h20, 6'h20, 6'h20},
      {6'h2A, 6'h15, 6'h00},
      {6'h2C, 6'h28, 6'h08},
      {6'h33, 6'h22, 6'h02}
   };

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [NUM_CH-1:0] exp_g);
      logic [IDX_W-1:0] exp_c;
      exp_c = '0;
      for (int i = 0; i < NUM_CH; i++) if (exp_g[i]) exp_c = IDX_W'(i);
      tests++;
      if (grant !== exp_g || cur_ch !== exp_c || busy !== (exp_g != '0)) begin
         fails++;
         $display("FAIL %s: grant=%h cur_ch=%0d busy=%b expected grant=%h cur_ch=%0d busy=%b",
                  req, grant, cur_ch, busy, exp_g, exp_c, (exp_g != '0));
      end
   endtask

   task automatic set_len(input int ch, input logic [LEN_W-1:0] v);
      ch_len[ch*LEN_W +: LEN_W] = v;
   endtask

   initial begin
      // R1 reset state
      #1;
      chk("R1 during reset", 6'h00);
      ch_active = 6'h3F; ch_req = 6'h3F;
      tick();
      chk("R1 reset holds off grant", 6'h00);
      ch_active = '0; ch_req = '0;
      rst_n = 1'b1;
      chk("R1 after reset", 6'h00);

      // table: R2 eligibility, R3 priority
      foreach (VEC[k]) begin
         ch_active = VEC[k][17:12];
         ch_req    = VEC[k][11:6];
         tick();
         chk("R2/R3 table", VEC[k][5:0]);
         ch_req = '0; cmd_end = 1'b1;
         tick();
         cmd_end = 1'b0;
         chk("R6 table release", 6'h00);
      end

      // R4/R5/R7 burst length and hold
      set_len(2, 4'd3);
      ch_active = 6'h04; ch_req = 6'h04;
      tick();
      chk("R8 grant on first eligible edge", 6'h04);
      beat = 1'b1;
      tick();                                   // 3 -> 2
      ch_active = 6'h05; ch_req = 6'h05;
      tick();                                   // 2 -> 1
      chk("R5 hold despite higher request", 6'h04);
      ch_req = 6'h01;
      tick();                                   // 1 -> 0
      chk("R4 fourth beat still owned", 6'h04);
      ch_req = 6'h05;
      tick();                                   // release, ch0 wins
      chk("R7 back-to-back to higher priority", 6'h01);
      tick();                                   // ch0 one-beat burst ends, re-granted
      chk("R7 released channel re-granted", 6'h01);
      ch_req = 6'h04;
      tick();
      chk("R7 switch to remaining requester", 6'h04);
      beat = 1'b0;
      ch_req = 6'h00;
      for (int n = 0; n < 5; n++) tick();
      chk("R10 no beats, grant held", 6'h04);
      cmd_end = 1'b1;
      tick();
      cmd_end = 1'b0;
      chk("R6 command end releases early", 6'h00);

      // R10 reload: ch3 length 1 gives two beats
      set_len(3, 4'd1);
      for (int n = 0; n < 3; n++) tick();
      chk("R8 idle with nothing eligible", 6'h00);
      ch_active = 6'h08; ch_req = 6'h08;
      tick();
      chk("R8 grant after idle", 6'h08);
      ch_req = 6'h00; beat = 1'b1;
      tick();
      chk("R10 first of two beats", 6'h08);
      tick();
      beat = 1'b0;
      chk("R4 release after L+1 beats", 6'h00);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule